// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes between a small processor bus and a three-wire synchronous serial link made of a shift clock, a transmit data line and a receive data line. Software writes a byte into the transmit holding register. The block copies it into a shift register and clocks it out, least significant bit first. At the same time it clocks eight bits in from the receive line and places them in a receive holding register. One shift clock serves both directions.

The shift clock comes either from an internal divider or from an external pin. The internal divider counts a reload value n, optionally after a divide-by-4 prescaler, and toggles the clock on each terminal count. The transmitter keeps the clock running across byte boundaries whenever the next byte is already waiting. Four status flags report progress: holding register empty, transfer finished, received byte waiting, and overrun. Two single-cycle interrupt pulses report transmit progress and receive arrival.

The register interface is a plain address/data bus. Reads are combinational and their side effects take place at the clock edge that ends the read cycle. There is no streaming handshake. Back-pressure is expressed through the flags instead: software should write a new byte only while the empty flag is 1, and should read the received byte before the next one completes.

Top module: `sio_sync_unit`

## Requirements
- R1: After reset the status register reads 0x03 (empty=1, finished=1, received=0, overrun=0). The shift clock output is 1, its output enable is 1, and both interrupt outputs are 0.
- R2: Register map. Address 0 writes the transmit holding register and reads the receive holding register. Address 1 reads status: bit0 empty, bit1 finished, bit2 received, bit3 overrun. Address 2 is control: bit0 selects the external clock, bit1 enables the divide-by-4 prescaler, bit2 moves the transmit interrupt to the finished event. Address 3 holds the 8-bit reload value n. Control and reload read back what was written.
- R3: With the internal clock, consecutive shift clock edges inside a transfer are exactly (n+1)*P cycles apart, where P is 4 with the prescaler and 1 without. Between transfers the shift clock is held high.
- R4: Each transfer is 8 bits, LSB first. The transmit line changes on a falling shift clock edge, and the receive line is sampled on a rising edge.
- R5: A write to address 0 clears the empty flag in the next cycle. If the block is idle, it loads the shifter one cycle later, which sets empty to 1 and finished to 0.
- R6: If a new byte is written before the eighth rising edge of the current byte, the next byte follows with the same edge spacing and no gap.
- R7: If no byte is waiting at the eighth rising edge, the finished flag sets, and the shift clock stays high with no further edges.
- R8: At the eighth rising edge the received byte enters the receive holding register and the received flag sets. A read of address 0 clears the received flag.
- R9: A byte that completes while the received flag is 1 sets the overrun flag and replaces the held byte. A read of address 0 alone does not clear overrun. A status read that sees overrun, followed by a read of address 0, clears it.
- R10: The transmit interrupt pulses for one cycle each time the empty flag is set by a shifter load when control bit2 is 0, and once when the finished flag sets when bit2 is 1.
- R11: The receive interrupt pulses for one cycle when the received flag goes from 0 to 1, and does not pulse on an overrun.
- R12: With the external clock selected, the output enable is 0 and the shift clock output stays high. The shifter moves on synchronised falling and rising edges of the external clock pin, with the same bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, side effects at the end of the cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internally generated shift clock |
| sclk_oe | output | 1 | 1 when the internal shift clock drives the pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A data write takes effect at its closing edge, so the empty flag reads 0 in the following cycle and the load shows up one cycle after that. The bench therefore reads status in the two bus cycles right after the write. Once the shifter is loaded, the first falling edge arrives (n+1)*P cycles later and each further edge follows (n+1)*P cycles after the one before. A monitor samples the pins on every falling clock edge, times each edge against that spacing, and treats the gap before a new transfer as exempt. The receive flag and the receive interrupt appear together at the eighth rising edge. Each transfer is awaited by bit count at the monitor before its flags are read, which keeps status polling away from the overrun clearing sequence.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_BAUD = 2'd3;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVR   = 3;

  typedef struct packed {
    logic irq_on_done;
    logic slow_src;
    logic ext_clk;
  } sio_ctrl_t;
endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int RELOAD_W = 8,
  parameter int PRESCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                slow_src,
  output logic                sclk,
  output logic                fall_stb,
  output logic                rise_stb
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0]       pre_cnt;
  logic [RELOAD_W-1:0] div_cnt;
  logic                en, tick;

  assign en       = slow_src ? (pre_cnt == PW'(PRESCALE-1)) : 1'b1;
  assign tick     = run && en && (div_cnt == '0);
  assign fall_stb = tick && sclk;
  assign rise_stb = tick && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      sclk    <= 1'b1;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= reload;
      sclk    <= 1'b1;
    end else begin
      if (pre_cnt == PW'(PRESCALE-1)) pre_cnt <= '0;
      else                            pre_cnt <= pre_cnt + 1'b1;
      if (en) begin
        if (div_cnt == '0) begin
          div_cnt <= reload;
          sclk    <= ~sclk;
        end else begin
          div_cnt <= div_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign fall = chain[STAGES] && !chain[STAGES-1];
  assign rise = !chain[STAGES] && chain[STAGES-1];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall_stb,
  input  logic              rise_stb,
  input  logic              rxd,
  output logic              txd,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CW = $clog2(DATA_W);

  logic [DATA_W-1:0] tsh, rsh;
  logic [CW-1:0]     bit_cnt;

  assign done    = rise_stb && (bit_cnt == CW'(DATA_W-1));
  assign rx_byte = {rxd, rsh[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh     <= '0;
      rsh     <= '0;
      bit_cnt <= '0;
      txd     <= 1'b1;
    end else begin
      if (load) begin
        tsh     <= load_data;
        bit_cnt <= '0;
      end else begin
        if (fall_stb) begin
          txd <= tsh[0];
          tsh <= tsh >> 1;
        end
        if (rise_stb) begin
          rsh     <= rx_byte;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_sync_unit.sv
module sio_sync_unit
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RELOAD_W    = 8,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              txd,
  input  logic              rxd,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int CTRL_W = $bits(sio_ctrl_t);

  sio_ctrl_t           ctrl_q;
  logic [RELOAD_W-1:0] baud_q;
  logic [DATA_W-1:0]   tbuf_q, rbuf_q;
  logic tbe_q, tsc_q, rbf_q, ovr_q, ovr_arm_q;

  logic wr_data, wr_ctrl, wr_baud, rd_data, rd_stat;
  logic active, gen_run, gen_sclk, gen_fall, gen_rise, ext_fall, ext_rise;
  logic fall_stb, rise_stb, done, start_load, cont_load, load, stop;
  logic [DATA_W-1:0] rx_byte;

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_baud = bus_wr && (bus_addr == ADDR_BAUD);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
  assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

  assign active  = !tsc_q;
  assign gen_run = active && !ctrl_q.ext_clk;

  sio_baud_gen #(.RELOAD_W(RELOAD_W), .PRESCALE(PRESCALE)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .reload(baud_q),
    .slow_src(ctrl_q.slow_src), .sclk(gen_sclk),
    .fall_stb(gen_fall), .rise_stb(gen_rise)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk_in), .fall(ext_fall), .rise(ext_rise)
  );

  assign fall_stb = active && (ctrl_q.ext_clk ? ext_fall : gen_fall);
  assign rise_stb = active && (ctrl_q.ext_clk ? ext_rise : gen_rise);

  assign start_load = tsc_q && !tbe_q;
  assign cont_load  = done && !tbe_q;
  assign load       = start_load || cont_load;
  assign stop       = done && tbe_q;

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tbuf_q),
    .fall_stb(fall_stb), .rise_stb(rise_stb), .rxd(rxd),
    .txd(txd), .done(done), .rx_byte(rx_byte)
  );

  assign sclk_out = ctrl_q.ext_clk ? 1'b1 : gen_sclk;
  assign sclk_oe  = !ctrl_q.ext_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      baud_q    <= '0;
      tbuf_q    <= '0;
      rbuf_q    <= '0;
      tbe_q     <= 1'b1;
      tsc_q     <= 1'b1;
      rbf_q     <= 1'b0;
      ovr_q     <= 1'b0;
      ovr_arm_q <= 1'b0;
      tx_irq    <= 1'b0;
      rx_irq    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= sio_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_baud) baud_q <= bus_wdata[RELOAD_W-1:0];
      if (wr_data) tbuf_q <= bus_wdata;

      if (wr_data)   tbe_q <= 1'b0;
      else if (load) tbe_q <= 1'b1;

      if (start_load) tsc_q <= 1'b0;
      else if (stop)  tsc_q <= 1'b1;

      if (done) rbuf_q <= rx_byte;

      if (done)         rbf_q <= 1'b1;
      else if (rd_data) rbf_q <= 1'b0;

      if (done && rbf_q && !rd_data)   ovr_q <= 1'b1;
      else if (rd_data && ovr_arm_q)   ovr_q <= 1'b0;

      if (rd_data)               ovr_arm_q <= 1'b0;
      else if (rd_stat && ovr_q) ovr_arm_q <= 1'b1;

      tx_irq <= ctrl_q.irq_on_done ? stop : load;
      rx_irq <= done && (!rbf_q || rd_data);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA: bus_rdata = rbuf_q;
      ADDR_STAT: begin
        bus_rdata[ST_EMPTY] = tbe_q;
        bus_rdata[ST_DONE]  = tsc_q;
        bus_rdata[ST_FULL]  = rbf_q;
        bus_rdata[ST_OVR]   = ovr_q;
      end
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      default:   bus_rdata[RELOAD_W-1:0] = baud_q;
    endcase
  end
endmodule

// File: rtl/sio_sync_unit_chk.sv
module sio_sync_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       sclk_out,
  input logic       tx_irq,
  input logic       rx_irq,
  input logic       tbe,
  input logic       tsc,
  input logic       rbf,
  input logic       ovr,
  input logic       ext_clk,
  input logic       irq_on_done
);
  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tsc && !ext_clk) |-> sclk_out); // R3
  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> !tbe); // R5
  AST_FINISH_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsc) |-> sclk_out); // R7
  AST_OVR_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> rbf); // R9
  AST_TXIRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (irq_on_done ? tsc : !tsc)); // R10
  AST_RXIRQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rbf); // R11
endmodule

bind sio_sync_unit sio_sync_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sclk_out(sclk_out), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .tbe(tbe_q), .tsc(tsc_q), .rbf(rbf_q), .ovr(ovr_q),
  .ext_clk(ctrl_q.ext_clk), .irq_on_done(ctrl_q.irq_on_done)
);

// File: tb/sim_sio_sync_unit.sv
`timescale 1ns/1ps
module sim_sio_sync_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sclk_in = 1'b1, sclk_out, sclk_oe, txd, rxd, tx_irq, rx_irq;
  logic       mon_rxd = 1'b1, ext_rxd = 1'b1, ext_mode = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] rx_q[$];
  int half_exp = 1, gap_cnt = 0, bytes_seen = 0, edge_cnt = 0;
  int tx_pulses = 0, rx_pulses = 0;

  always #2 clk = ~clk;
  assign rxd = ext_mode ? ext_rxd : mon_rxd;

  sio_sync_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .rxd(rxd),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pin-level scoreboard, sampled on the falling clock edge
  initial begin
    int cyc = 0, last_edge = 0, bitn = 0;
    bit last_s = 1'b1, boundary = 1'b1, have_edge = 1'b0;
    logic [7:0] got = '0, cur_rx = '0, exp;
    forever begin
      @(negedge clk);
      cyc++;
      if (tx_irq) tx_pulses++;
      if (rx_irq) rx_pulses++;
      if (rst_n && sclk_out != last_s) begin
        edge_cnt++;
        if (have_edge) begin
          if (boundary) begin
            if (cyc - last_edge != half_exp) gap_cnt++;
          end else
            check(cyc - last_edge == half_exp, "R3 edge spacing", cyc - last_edge, half_exp);
        end
        last_edge = cyc;
        have_edge = 1'b1;
        if (!sclk_out) begin
          if (bitn == 0) cur_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
          mon_rxd = cur_rx[bitn];
          boundary = 1'b0;
        end else begin
          got[bitn] = txd;
          bitn++;
          boundary = 1'b0;
          if (bitn == 8) begin
            exp = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hxx;
            check(got === exp, "R4 serial tx byte", got, exp);
            bytes_seen++;
            bitn = 0;
            boundary = 1'b1;
          end
        end
        last_s = sclk_out;
      end
    end
  end

  // Bus tasks: called at a falling clock edge, return at a falling clock edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    exp_tx.push_back(b);
    bus_write(2'd0, b);
  endtask

  task automatic wait_bytes(input int target);
    int guard = 0;
    while (bytes_seen < target && guard < 20000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_empty;
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      bus_read(2'd1, s);
      if (s[0]) break;
    end
  endtask

  initial begin
    logic [7:0] v;
    int t0, r0, e0, b0;
    logic [7:0] tx_b, rx_b, got_tx;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, v);
    check(v == 8'h03, "R1 status after reset", v, 8'h03);
    check(sclk_out && sclk_oe && !tx_irq && !rx_irq, "R1 pins after reset",
          {sclk_out, sclk_oe, tx_irq, rx_irq}, 4'b1100);

    // R2 register readback
    bus_write(2'd3, 8'h05);
    bus_write(2'd2, 8'h00);
    bus_read(2'd3, v);
    check(v == 8'h05, "R2 reload readback", v, 8'h05);
    bus_read(2'd2, v);
    check(v == 8'h00, "R2 control readback", v, 8'h00);

    // Single byte, n=5 no prescale: R3 R4 R5 R7 R8 R10 R11
    half_exp = 6;
    t0 = tx_pulses; r0 = rx_pulses; e0 = edge_cnt; b0 = bytes_seen;
    rx_q.push_back(8'hC3);
    send_byte(8'h3C);
    bus_read(2'd1, v);
    check(v[1:0] == 2'b10, "R5 empty cleared after write", v[1:0], 2'b10);
    bus_read(2'd1, v);
    check(v[1:0] == 2'b01, "R5 load sets empty, clears finished", v[1:0], 2'b01);
    wait_bytes(b0 + 1);
    bus_read(2'd1, v);
    check(v[2:0] == 3'b111, "R7 R8 finished and received after byte", v[2:0], 3'b111);
    repeat (20) @(negedge clk);
    check(edge_cnt - e0 == 16 && sclk_out, "R7 clock stops high", edge_cnt - e0, 16);
    check(tx_pulses - t0 == 1, "R10 tx irq on load", tx_pulses - t0, 1);
    check(rx_pulses - r0 == 1, "R11 rx irq on full", rx_pulses - r0, 1);
    bus_read(2'd0, v);
    check(v == 8'hC3, "R8 received byte", v, 8'hC3);
    bus_read(2'd1, v);
    check(v[2] == 1'b0, "R8 read clears received", v[2], 0);

    // Fastest clock n=0: R3 R4 R8 with two patterns
    bus_write(2'd3, 8'h00);
    half_exp = 1;
    rx_q.push_back(8'h81);
    b0 = bytes_seen;
    send_byte(8'hA5);
    wait_bytes(b0 + 1);
    bus_read(2'd0, v);
    check(v == 8'h81, "R8 received byte fast", v, 8'h81);
    rx_q.push_back(8'h7E);
    send_byte(8'h5A);
    wait_bytes(b0 + 2);
    bus_read(2'd0, v);
    check(v == 8'h7E, "R8 received byte fast second", v, 8'h7E);

    // Back-to-back with prescaler n=2, irq on finish: R3 R6 R10
    bus_write(2'd3, 8'h02);
    bus_write(2'd2, 8'h06);
    half_exp = 12;
    t0 = tx_pulses; b0 = bytes_seen;
    send_byte(8'h11);
    wait_empty();
    g0_reset: begin gap_cnt = gap_cnt; end
    send_byte(8'hE7);
    wait_empty();
    begin int gstart; gstart = gap_cnt;
      send_byte(8'h80);
      wait_bytes(b0 + 3);
      check(gap_cnt - gstart == 0, "R6 no gap between queued bytes", gap_cnt - gstart, 0);
    end
    check(tx_pulses - t0 == 1, "R10 tx irq on finish only", tx_pulses - t0, 1);
    bus_read(2'd2, v);
    check(v == 8'h06, "R2 control readback prescale", v, 8'h06);
    bus_read(2'd1, v);
    bus_read(2'd0, v);
    bus_read(2'd1, v);
    check(v[3:2] == 2'b00, "R9 flags clear after status+data read", v[3:2], 0);

    // Overrun, n=0: R9 R11
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h00);
    half_exp = 1;
    r0 = rx_pulses; b0 = bytes_seen;
    rx_q.push_back(8'h12); rx_q.push_back(8'h34);
    send_byte(8'h01);
    wait_bytes(b0 + 1);
    send_byte(8'h02);
    wait_bytes(b0 + 2);
    check(rx_pulses - r0 == 1, "R11 no rx irq on overrun", rx_pulses - r0, 1);
    bus_read(2'd0, v);
    check(v == 8'h34, "R9 overrun keeps newest byte", v, 8'h34);
    bus_read(2'd1, v);
    check(v[3:2] == 2'b10, "R9 data read alone keeps overrun", v[3:2], 2'b10);
    bus_read(2'd0, v);
    bus_read(2'd1, v);
    check(v[3] == 1'b0, "R9 overrun cleared by status then data", v[3], 0);

    // External clock: R12
    bus_write(2'd2, 8'h01);
    @(negedge clk);
    check(!sclk_oe && sclk_out, "R12 output disabled in external mode", {sclk_oe, sclk_out}, 2'b01);
    ext_mode = 1'b1;
    e0 = edge_cnt;
    tx_b = 8'h96; rx_b = 8'h4B; got_tx = '0;
    bus_write(2'd0, tx_b);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (2) @(negedge clk);
      ext_rxd = rx_b[i];
      repeat (6) @(negedge clk);
      got_tx[i] = txd;
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    check(got_tx == tx_b, "R12 external clock tx byte", got_tx, tx_b);
    bus_read(2'd0, v);
    check(v == rx_b, "R12 external clock rx byte", v, rx_b);
    bus_read(2'd1, v);
    check(v[1:0] == 2'b11, "R12 transfer finished", v[1:0], 2'b11);
    check(edge_cnt == e0, "R12 internal clock stays high", edge_cnt - e0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule